// File: doc/BRIEF.md
# Behavior Result Cache with Update Barrier

This block is a small fully associative table placed ahead of a long packet-processing pipeline. Each slot pairs a match key with a result word. A packet key presented on the lookup port is compared against every slot in one cycle. The registered answer either carries the stored result with a bypass flag, so the packet can skip the pipeline, or asks for full processing. Install requests write new key/result pairs. A free slot is taken first, and otherwise the slot installed longest ago is replaced. A key that is already present is rewritten in place and counts as freshly installed.

Changes to the pipeline's own tables enter through an update barrier. A request carries a key pattern and a bit mask, and the mask is narrowed to the key bits that a static field mask declares as cached. The barrier visits the slots one per cycle and clears every valid slot whose key agrees with the pattern on the narrowed bits. It then offers the update downstream on a valid/ready pair and pulses an acknowledge once that handshake is done. While the barrier is busy, installs are discarded, lookups are answered as misses, and further update requests are not accepted.

Top module: `bcache_top`

## Requirements
- R1: A lookup whose key equals a valid slot's key yields, on the clock edge that samples it, `lk_out_valid`=1, `lk_out_bypass`=1, `lk_out_full`=0 and `lk_out_result` equal to that slot's result.
- R2: A lookup with no matching valid slot yields `lk_out_valid`=1, `lk_out_bypass`=0, `lk_out_full`=1 and `lk_out_result`=0. After reset every lookup misses.
- R3: While at least one slot is free, an install never displaces a cached key, so ENTRIES distinct installs into an empty table all remain retrievable.
- R4: An install of a new key into a full table replaces the slot whose key was installed (or last re-installed) earliest.
- R5: An install of a key already cached overwrites that slot's result, does not use a second slot, and makes that slot the most recently installed.
- R6: An update request clears every valid slot whose key equals `upd_key` on all bits set in `upd_mask & fld_mask`. Other slots stay valid.
- R7: When `upd_mask & fld_mask` is zero, an update clears every slot.
- R8: `upd_busy` is 1 from the cycle after an update is accepted until the acknowledge cycle, inclusive. The sweep takes exactly ENTRIES cycles before `fwd_valid` rises.
- R9: After the sweep, `fwd_valid` stays 1 with `fwd_key`/`fwd_mask` equal to the request's key and mask until a cycle with `fwd_ready`=1.
- R10: `upd_ack` is a one-cycle pulse in the cycle after the forward handshake. It is never raised otherwise, and `upd_busy` falls after it.
- R11: An install presented while `upd_busy`=1 is discarded and leaves the table unchanged.
- R12: A lookup presented while `upd_busy`=1 is reported as a miss (`lk_out_bypass`=0), even if the key is cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fld_mask | input | KEY_W | Key bits that are cached fields (static) |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | KEY_W | Lookup key |
| lk_out_valid | output | 1 | Registered lookup answer valid |
| lk_out_bypass | output | 1 | Hit: packet skips the pipeline |
| lk_out_full | output | 1 | Miss: packet takes the full pipeline |
| lk_out_result | output | RES_W | Cached result on a hit, else zero |
| ins_valid | input | 1 | Install request |
| ins_key | input | KEY_W | Key to install |
| ins_result | input | RES_W | Result to install |
| upd_valid | input | 1 | Update request (accepted when not busy) |
| upd_key | input | KEY_W | Update key pattern |
| upd_mask | input | KEY_W | Update match mask |
| upd_busy | output | 1 | Barrier in progress |
| upd_ack | output | 1 | One-cycle update acknowledge |
| fwd_valid | output | 1 | Update offered downstream |
| fwd_key | output | KEY_W | Forwarded update key |
| fwd_mask | output | KEY_W | Forwarded update mask |
| fwd_ready | input | 1 | Downstream accepts the update |

## Verification
A wrong valid bit or a stale key shows up as a wrong bypass flag or result on the very next lookup of that key, one cycle after it is presented. A wrong install-age ordering shows only when the table is full and a new install replaces an entry, so the bench fills the table and probes every key it has ever used. A barrier fault that skips a slot, counts the sweep wrongly or acknowledges early appears within ENTRIES+2 cycles of the request, either as a surviving hit or as a misplaced `fwd_valid`/`upd_ack` edge.

// File: rtl/bcache_pkg.sv
// Shared types for the behavior result cache.
package bcache_pkg;
    // Barrier sequencer states.
    typedef enum logic [1:0] {
        BAR_IDLE  = 2'd0,
        BAR_SWEEP = 2'd1,
        BAR_FWD   = 2'd2,
        BAR_ACK   = 2'd3
    } bar_state_e;
endpackage

// File: rtl/bcache_store.sv
// Slot storage: valid bits, keys, results and install stamps.
// Compares one lookup key, one install key and one masked pattern
// against all slots each cycle.
// Assumes: a key is cached in at most one slot (the top guarantees it),
// and a write and a clear never target the same slot in one cycle.
module bcache_store #(
    parameter int N  = 16,
    parameter int KW = 32,
    parameter int RW = 16,
    parameter int TW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [KW-1:0]   lk_key,
    input  logic [KW-1:0]   ins_key,
    input  logic [KW-1:0]   pat_key,
    input  logic [KW-1:0]   pat_mask,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [RW-1:0]   wr_res,
    input  logic [TW-1:0]   wr_ts,
    input  logic            inv_en,
    input  logic [IW-1:0]   inv_idx,
    output logic [N-1:0]    vld_vec,
    output logic [N-1:0]    lk_hit_vec,
    output logic [N-1:0]    ins_hit_vec,
    output logic [N-1:0]    pat_vec,
    output logic [RW-1:0]   lk_res,
    output logic [N*TW-1:0] ts_flat
);
    logic [N-1:0]  vld_q;
    logic [KW-1:0] key_q [N];
    logic [RW-1:0] res_q [N];
    logic [TW-1:0] ts_q  [N];

    // Valid bits: set on install, cleared by the barrier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (wr_en)  vld_q[wr_idx]  <= 1'b1;
            if (inv_en) vld_q[inv_idx] <= 1'b0;
        end
    end

    // Slot payload: key, result and install stamp.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_q[wr_idx] <= ins_key;
            res_q[wr_idx] <= wr_res;
            ts_q[wr_idx]  <= wr_ts;
        end
    end

    // Per-slot comparators.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign lk_hit_vec[g]  = vld_q[g] && (key_q[g] == lk_key);
        assign ins_hit_vec[g] = vld_q[g] && (key_q[g] == ins_key);
        assign pat_vec[g]     = vld_q[g] && (((key_q[g] ^ pat_key) & pat_mask) == '0);
        assign ts_flat[g*TW +: TW] = ts_q[g];
    end

    assign vld_vec = vld_q;

    // Result select: OR of the single hitting slot's result.
    always_comb begin
        lk_res = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_hit_vec[i]) lk_res = lk_res | res_q[i];
        end
    end
endmodule

// File: rtl/bcache_victim.sv
// Picks the slot an install writes: the slot already holding the key,
// else the lowest free slot, else the slot with the greatest age
// (now - stamp, modulo 2^TW). Ties go to the lowest index.
// Assumes: entries are refreshed or replaced within 2^TW cycles,
// so that the age difference is unambiguous.
module bcache_victim #(
    parameter int N  = 16,
    parameter int TW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]    vld_vec,
    input  logic [N-1:0]    ins_hit_vec,
    input  logic [N*TW-1:0] ts_flat,
    input  logic [TW-1:0]   now,
    output logic [IW-1:0]   sel_idx
);
    logic          free_any, same_any;
    logic [IW-1:0] free_idx, same_idx, old_idx;
    logic [TW-1:0] old_age;

    // Priority search over all slots for each candidate kind.
    always_comb begin
        logic [TW-1:0] age;
        free_any = 1'b0;
        same_any = 1'b0;
        free_idx = '0;
        same_idx = '0;
        old_idx  = '0;
        old_age  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
            if (ins_hit_vec[i]) begin
                same_any = 1'b1;
                same_idx = IW'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            age = now - ts_flat[i*TW +: TW];
            if (i == 0 || age > old_age) begin
                old_age = age;
                old_idx = IW'(i);
            end
        end
        if (same_any)      sel_idx = same_idx;
        else if (free_any) sel_idx = free_idx;
        else               sel_idx = old_idx;
    end
endmodule

// File: rtl/bcache_barrier.sv
// Update barrier sequencer. It captures a request, sweeps the slots one
// per cycle and clears those matching the masked pattern, then offers
// the update downstream and pulses an acknowledge after the handshake.
// Assumes: fld_mask is static while a barrier runs.
module bcache_barrier #(
    parameter int N  = 16,
    parameter int KW = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_valid,
    input  logic [KW-1:0] upd_key,
    input  logic [KW-1:0] upd_mask,
    input  logic [KW-1:0] fld_mask,
    input  logic [N-1:0]  pat_vec,
    input  logic          fwd_ready,
    output logic [KW-1:0] pat_key,
    output logic [KW-1:0] pat_mask,
    output logic          inv_en,
    output logic [IW-1:0] inv_idx,
    output logic          busy,
    output logic          fwd_valid,
    output logic [KW-1:0] fwd_key,
    output logic [KW-1:0] fwd_mask,
    output logic          ack
);
    import bcache_pkg::*;

    bar_state_e    st_q;
    logic [IW-1:0] idx_q;
    logic [KW-1:0] key_q, mask_q;

    // Sequencer: idle -> sweep N slots -> forward -> acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BAR_IDLE;
            idx_q  <= '0;
            key_q  <= '0;
            mask_q <= '0;
        end else begin
            case (st_q)
                BAR_IDLE: if (upd_valid) begin
                    st_q   <= BAR_SWEEP;
                    idx_q  <= '0;
                    key_q  <= upd_key;
                    mask_q <= upd_mask;
                end
                BAR_SWEEP: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IW'(N - 1)) st_q <= BAR_FWD;
                end
                BAR_FWD: if (fwd_ready) st_q <= BAR_ACK;
                default: st_q <= BAR_IDLE;
            endcase
        end
    end

    assign pat_key   = key_q;
    assign pat_mask  = mask_q & fld_mask;
    assign inv_idx   = idx_q;
    assign inv_en    = (st_q == BAR_SWEEP) && pat_vec[idx_q];
    assign busy      = (st_q != BAR_IDLE);
    assign fwd_valid = (st_q == BAR_FWD);
    assign fwd_key   = key_q;
    assign fwd_mask  = mask_q;
    assign ack       = (st_q == BAR_ACK);
endmodule

// File: rtl/bcache_top.sv
// Behavior result cache top. Holds the install-stamp counter, gates
// installs and lookups with the barrier's busy flag and registers the
// lookup answer.
// Assumes: upstream never relies on an install made while busy.
module bcache_top #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 32,
    parameter int RES_W   = 16,
    parameter int TS_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] fld_mask,
    input  logic             lk_valid,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_out_valid,
    output logic             lk_out_bypass,
    output logic             lk_out_full,
    output logic [RES_W-1:0] lk_out_result,
    input  logic             ins_valid,
    input  logic [KEY_W-1:0] ins_key,
    input  logic [RES_W-1:0] ins_result,
    input  logic             upd_valid,
    input  logic [KEY_W-1:0] upd_key,
    input  logic [KEY_W-1:0] upd_mask,
    output logic             upd_busy,
    output logic             upd_ack,
    output logic             fwd_valid,
    output logic [KEY_W-1:0] fwd_key,
    output logic [KEY_W-1:0] fwd_mask,
    input  logic             fwd_ready
);
    localparam int IW = $clog2(ENTRIES);

    logic [TS_W-1:0]         now_q;
    logic [ENTRIES-1:0]      vld_vec, lk_hit_vec, ins_hit_vec, pat_vec;
    logic [RES_W-1:0]        lk_res;
    logic [ENTRIES*TS_W-1:0] ts_flat;
    logic [IW-1:0]           sel_idx, inv_idx;
    logic [KEY_W-1:0]        pat_key, pat_mask;
    logic                    inv_en, busy, wr_en, hit_now;

    // Free-running install stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    assign wr_en   = ins_valid && !busy;
    assign hit_now = lk_valid && !busy && (|lk_hit_vec);

    bcache_store #(.N(ENTRIES), .KW(KEY_W), .RW(RES_W), .TW(TS_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_key     (lk_key),
        .ins_key    (ins_key),
        .pat_key    (pat_key),
        .pat_mask   (pat_mask),
        .wr_en      (wr_en),
        .wr_idx     (sel_idx),
        .wr_res     (ins_result),
        .wr_ts      (now_q),
        .inv_en     (inv_en),
        .inv_idx    (inv_idx),
        .vld_vec    (vld_vec),
        .lk_hit_vec (lk_hit_vec),
        .ins_hit_vec(ins_hit_vec),
        .pat_vec    (pat_vec),
        .lk_res     (lk_res),
        .ts_flat    (ts_flat)
    );

    bcache_victim #(.N(ENTRIES), .TW(TS_W)) u_victim (
        .vld_vec    (vld_vec),
        .ins_hit_vec(ins_hit_vec),
        .ts_flat    (ts_flat),
        .now        (now_q),
        .sel_idx    (sel_idx)
    );

    bcache_barrier #(.N(ENTRIES), .KW(KEY_W)) u_barrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_valid(upd_valid),
        .upd_key  (upd_key),
        .upd_mask (upd_mask),
        .fld_mask (fld_mask),
        .pat_vec  (pat_vec),
        .fwd_ready(fwd_ready),
        .pat_key  (pat_key),
        .pat_mask (pat_mask),
        .inv_en   (inv_en),
        .inv_idx  (inv_idx),
        .busy     (busy),
        .fwd_valid(fwd_valid),
        .fwd_key  (fwd_key),
        .fwd_mask (fwd_mask),
        .ack      (upd_ack)
    );

    // Registered lookup answer; a busy barrier forces a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_out_valid  <= 1'b0;
            lk_out_bypass <= 1'b0;
            lk_out_result <= '0;
        end else begin
            lk_out_valid  <= lk_valid;
            lk_out_bypass <= hit_now;
            lk_out_result <= hit_now ? lk_res : '0;
        end
    end

    assign lk_out_full = lk_out_valid && !lk_out_bypass;
    assign upd_busy    = busy;
endmodule

// File: rtl/bcache_chk.sv
// Protocol checker for bcache_top, attached by bind.
module bcache_chk #(
    parameter int N  = 16,
    parameter int KW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic          lk_out_valid,
    input logic          lk_out_bypass,
    input logic          upd_valid,
    input logic          upd_busy,
    input logic          upd_ack,
    input logic          fwd_valid,
    input logic          fwd_ready,
    input logic [KW-1:0] fwd_key
);
    logic [31:0] busy_cnt;

    // Counts consecutive busy cycles for the sweep-length check.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_cnt <= '0;
        else if (upd_busy) busy_cnt <= busy_cnt + 1'b1;
        else               busy_cnt <= '0;
    end

    // R1
    bypass_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_out_bypass |-> lk_out_valid);

    // R8
    busy_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_busy) |=> upd_busy);

    // R8
    sweep_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ack |-> (busy_cnt >= 32'(N + 1)));

    // R9
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_key)));

    // R9
    fwd_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> upd_busy);

    // R10
    ack_after_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ack |-> $past(fwd_valid && fwd_ready));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ack |=> (!upd_ack && !upd_busy));

    // R12
    busy_forces_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && upd_busy) |=> !lk_out_bypass);
endmodule

bind bcache_top bcache_chk #(.N(ENTRIES), .KW(KEY_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_out_valid (lk_out_valid),
    .lk_out_bypass(lk_out_bypass),
    .upd_valid    (upd_valid),
    .upd_busy     (upd_busy),
    .upd_ack      (upd_ack),
    .fwd_valid    (fwd_valid),
    .fwd_ready    (fwd_ready),
    .fwd_key      (fwd_key)
);

// File: tb/tb_bcache_top.sv
// Directed bench for bcache_top with a reference model built from the requirements.
module tb_bcache_top;
    localparam int N  = 16;
    localparam int KW = 32;
    localparam int RW = 16;
    localparam int NK = 20;
    localparam logic [KW-1:0] FLD = 32'hFFFF_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [KW-1:0] fld_mask = FLD;
    logic          lk_valid = 1'b0;
    logic [KW-1:0] lk_key = '0;
    logic          lk_out_valid, lk_out_bypass, lk_out_full;
    logic [RW-1:0] lk_out_result;
    logic          ins_valid = 1'b0;
    logic [KW-1:0] ins_key = '0;
    logic [RW-1:0] ins_result = '0;
    logic          upd_valid = 1'b0;
    logic [KW-1:0] upd_key = '0, upd_mask = '0;
    logic          upd_busy, upd_ack, fwd_valid;
    logic [KW-1:0] fwd_key, fwd_mask;
    logic          fwd_ready = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    // Model: slot contents and install order.
    logic          m_vld [N];
    logic [KW-1:0] m_key [N];
    logic [RW-1:0] m_res [N];
    int            m_seq [N];
    int            seq_ctr = 0;

    always #2 clk = ~clk;

    bcache_top #(.ENTRIES(N), .KEY_W(KW), .RES_W(RW), .TS_W(16)) dut (.*);

    function automatic logic [KW-1:0] key_of(int i);
        return {16'(i & 3), 16'(16'h1000 + i)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_insert(logic [KW-1:0] k, logic [RW-1:0] r);
        int s = -1;
        for (int i = 0; i < N; i++) if (s < 0 && m_vld[i] && m_key[i] == k) s = i;
        for (int i = 0; i < N; i++) if (s < 0 && !m_vld[i]) s = i;
        if (s < 0) begin
            s = 0;
            for (int i = 1; i < N; i++) if (m_seq[i] < m_seq[s]) s = i;
        end
        m_vld[s] = 1'b1; m_key[s] = k; m_res[s] = r; m_seq[s] = seq_ctr++;
    endtask

    task automatic do_insert(int i, logic [RW-1:0] r);
        @(negedge clk);
        ins_valid = 1'b1; ins_key = key_of(i); ins_result = r;
        @(negedge clk);
        ins_valid = 1'b0;
        model_insert(key_of(i), r);
    endtask

    task automatic do_lookup(logic [KW-1:0] k, string req);
        logic          eh = 1'b0;
        logic [RW-1:0] er = '0;
        for (int i = 0; i < N; i++) if (m_vld[i] && m_key[i] == k) begin eh = 1'b1; er = m_res[i]; end
        @(negedge clk);
        lk_valid = 1'b1; lk_key = k;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, {lk_out_valid, lk_out_bypass, lk_out_full}, {1'b1, eh, !eh}, "valid/bypass/full");
        chk(req, lk_out_result, er, "result");
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < NK; i++) do_lookup(key_of(i), req);
    endtask

    // Barrier scenario; probe issues a lookup and an install during the sweep.
    task automatic do_update(logic [KW-1:0] k, logic [KW-1:0] m, bit probe);
        int cnt = 0;
        @(negedge clk);
        upd_valid = 1'b1; upd_key = k; upd_mask = m;
        @(negedge clk);
        upd_valid = 1'b0;
        chk("R8", upd_busy, 1, "busy after request");
        while (!fwd_valid && cnt < 1000) begin
            cnt++;
            if (probe && cnt == 1) begin
                lk_valid = 1'b1; lk_key = key_of(4);
                ins_valid = 1'b1; ins_key = key_of(18); ins_result = 16'hBEEF;
            end
            if (probe && cnt == 2) begin
                lk_valid = 1'b0; ins_valid = 1'b0;
                chk("R12", {lk_out_valid, lk_out_bypass}, 2'b10, "lookup while busy");
            end
            chk("R10", upd_ack, 0, "ack during sweep");
            @(negedge clk);
        end
        chk("R8", cnt, N, "sweep cycles");
        for (int w = 0; w < 3; w++) begin
            chk("R9", {fwd_valid, upd_ack}, 2'b10, "fwd held, no ack");
            chk("R9", {fwd_key, fwd_mask}, {k, m}, "fwd key/mask");
            @(negedge clk);
        end
        fwd_ready = 1'b1;
        @(negedge clk);
        fwd_ready = 1'b0;
        chk("R10", {upd_ack, fwd_valid, upd_busy}, 3'b101, "ack after handshake");
        @(negedge clk);
        chk("R10", {upd_ack, upd_busy}, 2'b00, "ack is one cycle");
        for (int i = 0; i < N; i++)
            if (((m_key[i] ^ k) & (m & FLD)) == '0) m_vld[i] = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_key[i] = '0; m_res[i] = '0; m_seq[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R2", {lk_out_valid, lk_out_bypass, upd_busy, upd_ack, fwd_valid}, 5'b0, "reset state");
        do_lookup(key_of(0), "R2");
        for (int i = 0; i < N; i++) do_insert(i, 16'hA000 + 16'(i));
        check_all("R3");
        do_insert(16, 16'hA010);
        check_all("R4");
        do_insert(1, 16'h5151);
        do_insert(17, 16'hA011);
        check_all("R5");
        do_lookup(key_of(1), "R1");
        do_update({16'h0001, 16'h0000}, 32'hFFFF_FFFF, 1'b1);
        check_all("R6");
        do_lookup(key_of(18), "R11");
        do_update(32'h0, 32'h0000_FFFF, 1'b0);
        check_all("R7");
        do_insert(6, 16'h6666);
        do_lookup(key_of(6), "R1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule